// File: doc/BRIEF.md
# Switch-On Delay Sequencer

This block steps a picture-tube drive path through its power-up stages. Right after power comes up the cathodes are cold. The sequencer then holds the colour outputs at ultra-black for the whole active line scan. In each vertical blanking interval it asks for a white-level monitor pulse, which lets the analog side watch the cathode warm up. When an external comparator reports that the warm-up threshold has been crossed, the monitor pulse stops and the cut-off and white-level loops are enabled. Line-scan blanking stays on until the cut-off loop reports that it has settled. After that the picture is released.

Phase changes happen only at the end of a vertical blanking interval, so a field is never split between two behaviours. The two analog flags pass through a synchronizer chain of `SYNC_STAGES` flip-flops before they are used. A synchronous power-on reset event puts the sequence back at the start from any phase. The current phase is brought out on a 2-bit port for observation.

Top module: `switchOnSeq`

## Requirements
- R1: After `rstN` is released, `phaseOut` is 2'd0 (warm-up), `ctrlEnable` is 0 and `monitorPulse` is 0.
- R2: In phase 2'd0, while the delayed blanking view is 0 (line scan), `lineBlank`=1 and `monitorPulse`=0. While it is 1, `lineBlank`=0 and `monitorPulse`=1. `ctrlEnable` is 0 throughout.
- R3: The delayed blanking view is the value of `vBlank` sampled at the previous clock edge, so every output follows a `vBlank` change exactly one cycle later.
- R4: A blanking end is a cycle in which `vBlank`=0 and the previous sampled `vBlank` was 1. In phase 2'd0 at a blanking end, if the synchronized warm flag is 1, the phase becomes 2'd1 at the closing clock edge. The synchronized warm flag is `warmDone` as sampled `SYNC_STAGES` edges earlier (default 2).
- R5: In phase 2'd1, `ctrlEnable`=1, `monitorPulse`=0, and `lineBlank` equals the inverse of the delayed blanking view.
- R6: In phase 2'd1 at a blanking end, if the synchronized stable flag is 1, the phase becomes 2'd2. This flag is `cutoffStable` delayed the same way as in R4.
- R7: In phase 2'd2, `lineBlank`=0, `monitorPulse`=0 and `ctrlEnable`=1, and the phase stays at 2'd2 until a power-on reset event.
- R8: Outside a blanking end and without `porEvent`, the phase does not change, whatever the flags do.
- R9: A stable flag seen in phase 2'd0 is ignored. A blanking end with both flags set advances only to 2'd1.
- R10: `porEvent`=1 in any cycle makes the phase 2'd0 at the next edge. This takes priority over any advance.
- R11: `monitorPulse` and `ctrlEnable` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| porEvent | input | 1 | Synchronous power-on reset event |
| vBlank | input | 1 | Vertical blanking interval flag |
| warmDone | input | 1 | Warm-up threshold comparator flag (asynchronous) |
| cutoffStable | input | 1 | Cut-off loop settled flag (asynchronous) |
| lineBlank | output | 1 | Blank outputs to ultra-black during line scan |
| monitorPulse | output | 1 | Request white-level monitor pulse |
| ctrlEnable | output | 1 | Enable cut-off and white-level control |
| phaseOut | output | 2 | Current phase: 0 warm-up, 1 settle, 2 run |

## Verification
A wrong phase register shows at the ports in the first cycle after the faulty edge, through `phaseOut` and through the output pattern of that phase. A wrong blanking delay shows as outputs that switch one cycle early or late around every `vBlank` edge. Misjudged flag timing, such as a wrong synchronizer depth or an advance taken mid-field, shows as a phase step on the wrong cycle compared with a model that tracks the delayed flags. The random fields with rare power-on events reach every phase many times. The directed sequence covers both flags set at once and a reset event issued from the run phase.

// File: rtl/seqPkg.sv
package seqPkg;
  typedef enum logic [1:0] {
    PH_WARM   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_RUN    = 2'd2
  } phase_e;

  typedef struct packed {
    logic fieldEnd;
    logic warmReady;
    logic stableReady;
  } seqStrobe_t;
endpackage

// File: rtl/flagSync.sv
module flagSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  generate
    if (STAGES == 0) begin : gPass
      assign dout = din;
    end else begin : gChain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          q <= '0;
        end else begin
          q[0] <= din;
          for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
        end
      end
      assign dout = q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vBlank,
  input  logic       warmDone,
  input  logic       cutoffStable,
  input  phase_e     phase,
  output seqStrobe_t strobe,
  output logic       lineBlank,
  output logic       monitorPulse,
  output logic       ctrlEnable
);
  logic vbQ;
  logic warmSync;
  logic stableSync;

  flagSync #(.STAGES(SYNC_STAGES)) uWarm (
    .clk(clk), .rstN(rstN), .din(warmDone), .dout(warmSync)
  );
  flagSync #(.STAGES(SYNC_STAGES)) uStable (
    .clk(clk), .rstN(rstN), .din(cutoffStable), .dout(stableSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vbQ <= 1'b0;
    else       vbQ <= vBlank;
  end

  always_comb begin
    strobe.fieldEnd    = vbQ & ~vBlank;
    strobe.warmReady   = warmSync;
    strobe.stableReady = stableSync;
  end

  // Outputs use the registered blanking view so a whole field shifts as one.
  always_comb begin
    lineBlank    = ~vbQ & (phase != PH_RUN);
    monitorPulse = vbQ & (phase == PH_WARM);
    ctrlEnable   = (phase != PH_WARM);
  end
endmodule

// File: rtl/seqControl.sv
module seqControl
  import seqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       porEvent,
  input  seqStrobe_t strobe,
  output phase_e     phase
);
  phase_e phaseNext;

  always_comb begin
    phaseNext = phase;
    if (porEvent) begin
      phaseNext = PH_WARM;
    end else if (strobe.fieldEnd) begin
      unique case (phase)
        PH_WARM:   if (strobe.warmReady)   phaseNext = PH_SETTLE;
        PH_SETTLE: if (strobe.stableReady) phaseNext = PH_RUN;
        PH_RUN:    phaseNext = PH_RUN;
        default:   phaseNext = PH_WARM;
      endcase
    end else if (phase != PH_WARM && phase != PH_SETTLE && phase != PH_RUN) begin
      phaseNext = PH_WARM;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_WARM;
    else       phase <= phaseNext;
  end
endmodule

// File: rtl/switchOnSeq.sv
module switchOnSeq
  import seqPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       porEvent,
  input  logic       vBlank,
  input  logic       warmDone,
  input  logic       cutoffStable,
  output logic       lineBlank,
  output logic       monitorPulse,
  output logic       ctrlEnable,
  output logic [1:0] phaseOut
);
  seqStrobe_t strobe;
  phase_e     phase;

  seqDatapath #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .vBlank(vBlank), .warmDone(warmDone),
    .cutoffStable(cutoffStable), .phase(phase), .strobe(strobe),
    .lineBlank(lineBlank), .monitorPulse(monitorPulse), .ctrlEnable(ctrlEnable)
  );

  seqControl uCtl (
    .clk(clk), .rstN(rstN), .porEvent(porEvent), .strobe(strobe), .phase(phase)
  );

  assign phaseOut = phase;
endmodule

// File: rtl/switchOnSeqChk.sv
module switchOnSeqChk (
  input logic       clk,
  input logic       rstN,
  input logic       porEvent,
  input logic       vBlank,
  input logic       lineBlank,
  input logic       monitorPulse,
  input logic       ctrlEnable,
  input logic [1:0] phaseOut
);
  logic vbPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vbPrev <= 1'b0;
    else       vbPrev <= vBlank;
  end

  a_r10_por_to_warm: assert property (@(posedge clk) disable iff (!rstN)
    porEvent |=> phaseOut == 2'd0);

  a_r8_hold_mid_field: assert property (@(posedge clk) disable iff (!rstN)
    (!porEvent && !(vbPrev && !vBlank)) |=> $stable(phaseOut));

  a_r9_no_skip: assert property (@(posedge clk) disable iff (!rstN)
    (phaseOut == 2'd0) |=> phaseOut != 2'd2);

  a_r7_run_outputs: assert property (@(posedge clk) disable iff (!rstN)
    (phaseOut == 2'd2) |-> (!lineBlank && !monitorPulse && ctrlEnable));

  a_r7_run_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (phaseOut == 2'd2 && !porEvent) |=> phaseOut == 2'd2);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(monitorPulse && ctrlEnable));

  a_r3_monitor_follows: assert property (@(posedge clk) disable iff (!rstN)
    (phaseOut == 2'd0 && !porEvent && !(vbPrev && !vBlank)) |=> monitorPulse == $past(vBlank));
endmodule

bind switchOnSeq switchOnSeqChk uChk (
  .clk(clk), .rstN(rstN), .porEvent(porEvent), .vBlank(vBlank),
  .lineBlank(lineBlank), .monitorPulse(monitorPulse),
  .ctrlEnable(ctrlEnable), .phaseOut(phaseOut)
);

// File: tb/sim_switchOnSeq.sv
module sim_switchOnSeq;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic porEvent = 1'b0, vBlank = 1'b0, warmDone = 1'b0, cutoffStable = 1'b0;
  logic lineBlank, monitorPulse, ctrlEnable;
  logic [1:0] phaseOut;

  int nChecks = 0, nBad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  switchOnSeq #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rstN(rstN), .porEvent(porEvent), .vBlank(vBlank),
    .warmDone(warmDone), .cutoffStable(cutoffStable), .lineBlank(lineBlank),
    .monitorPulse(monitorPulse), .ctrlEnable(ctrlEnable), .phaseOut(phaseOut)
  );

  // Reference model built from the requirements
  logic [1:0] mPhase;
  logic mVbq;
  logic [SYNC-1:0] mWarmHist, mStableHist;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase <= 2'd0; mVbq <= 1'b0; mWarmHist <= '0; mStableHist <= '0;
    end else begin
      if (porEvent) mPhase <= 2'd0;
      else if (mVbq && !vBlank) begin
        if (mPhase == 2'd0 && mWarmHist[SYNC-1]) mPhase <= 2'd1;
        else if (mPhase == 2'd1 && mStableHist[SYNC-1]) mPhase <= 2'd2;
      end
      mVbq <= vBlank;
      mWarmHist <= {mWarmHist[SYNC-2:0], warmDone};
      mStableHist <= {mStableHist[SYNC-2:0], cutoffStable};
    end
  end

  function automatic logic expLineBlank(input logic [1:0] ph, input logic vbq);
    return !vbq && ph != 2'd2;
  endfunction
  function automatic logic expMonitor(input logic [1:0] ph, input logic vbq);
    return vbq && ph == 2'd0;
  endfunction
  function automatic logic expCtrl(input logic [1:0] ph);
    return ph != 2'd0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelCheck();
    chk("R4 R6 R8 R10 phase", phaseOut, mPhase);
    chk("R2 R3 R5 R7 lineBlank", lineBlank, expLineBlank(mPhase, mVbq));
    chk("R2 R3 monitorPulse", monitorPulse, expMonitor(mPhase, mVbq));
    chk("R5 R7 ctrlEnable", ctrlEnable, expCtrl(mPhase));
    chk("R11 exclusive", monitorPulse & ctrlEnable, 0);
  endtask

  task automatic step(input logic vb, input logic wd, input logic cs, input logic pe);
    @(negedge clk);
    modelCheck();
    vBlank = vb; warmDone = wd; cutoffStable = cs; porEvent = pe;
  endtask

  task automatic steps(input int n, input logic vb, input logic wd, input logic cs);
    for (int i = 0; i < n; i++) step(vb, wd, cs, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset phase", phaseOut, 0);
    chk("R1 reset ctrlEnable", ctrlEnable, 0);
    chk("R1 reset monitorPulse", monitorPulse, 0);

    // both flags set while scanning: no change mid-field (R8)
    steps(10, 1'b0, 1'b1, 1'b1);
    chk("R8 no advance mid-scan", phaseOut, 0);
    chk("R2 scan blanked", lineBlank, 1);
    step(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R3 monitor not yet", monitorPulse, 0);
    step(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R3 monitor one cycle later", monitorPulse, 1);
    chk("R2 no line blank in blanking", lineBlank, 0);
    step(1'b1, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R8 still warm at end cycle", phaseOut, 0);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R4 advanced to settle", phaseOut, 1);
    chk("R9 stable ignored in warm", phaseOut != 2'd2, 1);
    chk("R5 ctrl enabled", ctrlEnable, 1);
    chk("R5 scan still blanked", lineBlank, 1);
    steps(5, 1'b0, 1'b1, 1'b1);
    steps(3, 1'b1, 1'b1, 1'b1);
    chk("R5 no monitor in settle", monitorPulse, 0);
    steps(2, 1'b0, 1'b1, 1'b1);
    chk("R6 advanced to run", phaseOut, 2);
    chk("R7 unblanked", lineBlank, 0);
    step(1'b0, 1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R10 por returns to warm", phaseOut, 0);
    chk("R10 ctrl off", ctrlEnable, 0);

    // constrained random fields
    void'($urandom(32'd1234));
    for (int f = 0; f < 300; f++) begin
      automatic logic wd = ($urandom_range(99) < 45);
      automatic logic cs = ($urandom_range(99) < 35);
      automatic int nScan = $urandom_range(10, 2);
      automatic int nBl = $urandom_range(6, 1);
      for (int i = 0; i < nScan; i++) begin
        if ($urandom_range(99) < 10) wd = ~wd;
        if ($urandom_range(99) < 10) cs = ~cs;
        step(1'b0, wd, cs, ($urandom_range(299) == 0));
      end
      for (int i = 0; i < nBl; i++) step(1'b1, wd, cs, ($urandom_range(299) == 0));
    end
    step(1'b0, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end
endmodule